// File: doc/BRIEF.md
# Carry Skip Adder

A purely combinational two's-complement adder of parametric width (16 bits by default). It adds two operands and a carry-in, and it returns the sum and the carry-out. The operand is cut into equal ripple groups, four bits wide by default. Each bit first forms its own propagate flag (XOR of the operand bits) and its own generate flag (AND of the operand bits). Each group then ripples its carry from bit to bit.

A group whose bits all propagate cannot change the carry that enters it. For that group a 2:1 selector forwards the incoming carry directly to the next group and skips the internal chain. The sum bits of every group still come from that group's own ripple chain, which is fed by the carry that truly enters it.

The per-group all-propagate flags are brought out so that a timing or test environment can see which groups take the bypass. A parameter chooses between the bypassed structure and a plain ripple build. The plain ripple build is useful for area comparison.

Top module: `carry_skip_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit result `a_i + b_i + cin_i`.
- R3: `grp_prop_o[k]` is 1 exactly when `a_i ^ b_i` is all ones over bits 4k to 4k+3, so bit 0 covers bits 3..0 and bit 3 covers bits 15..12.
- R4: When every bit propagates (`b_i == ~a_i`), `grp_prop_o` reads 4'b1111 and `cout_o` equals `cin_i`. In that case `sum_o` reads 16'hFFFF with `cin_i` = 0 and 16'h0000 with `cin_i` = 1.
- R5: A carry generated in the bit just below a fully propagating group crosses that group. That group's four sum bits read zero, and the carry arrives at the first bit above the group.
- R6: A carry produced at bit 0 travels through every higher group: 16'hFFFF + 16'h0001 gives `sum_o` = 0, `cout_o` = 1 and `grp_prop_o` = 4'b1110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_prop_o | output | 4 | All-propagate flag of each 4-bit group, bit k for bits 4k..4k+3 |

## Verification
The immediate assertions take for granted that every operand and carry-in bit is a known 0 or 1 and that the inputs have settled; they skip evaluation while any input is unknown. The stimulus drives every input bit on each cycle and changes the inputs only at a rising edge. Outputs are read half a period later, so no check or assertion sees a partly updated operand.

// File: rtl/cba_pkg.sv
package cba_pkg;

   // Per-bit carry terms formed from one operand bit pair
   typedef struct packed {
      logic prop;
      logic gen;
   } pg_bit_t;

   // Number of groups a width splits into
   function automatic int unsigned grp_count(input int unsigned width, input int unsigned grp_w);
      return width / grp_w;
   endfunction

endpackage

// File: rtl/cba_pg_cell.sv
module cba_pg_cell
   import cba_pkg::*;
(
   input  logic    a_i,
   input  logic    b_i,
   output pg_bit_t pg_o
);

   assign pg_o.prop = a_i ^ b_i;
   assign pg_o.gen  = a_i & b_i;

   // R3: a bit cannot both propagate and generate
   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         p_pg_exclusive_r3: assert (!(pg_o.prop && pg_o.gen))
            else $error("propagate and generate both high");
      end
   end

endmodule

// File: rtl/cba_ripple_group.sv
module cba_ripple_group
   import cba_pkg::*;
#(
   parameter int unsigned GRP_W = 4
)(
   input  pg_bit_t [GRP_W-1:0] pg_i,
   input  logic                cin_i,
   output logic    [GRP_W-1:0] sum_o,
   output logic                rip_cout_o,
   output logic                blk_prop_o
);

   logic [GRP_W:0]   chain;
   logic [GRP_W-1:0] props;
   logic [GRP_W-1:0] gens;

   assign chain[0] = cin_i;

   for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      assign props[i]    = pg_i[i].prop;
      assign gens[i]     = pg_i[i].gen;
      assign chain[i+1]  = pg_i[i].gen | (pg_i[i].prop & chain[i]);
      assign sum_o[i]    = pg_i[i].prop ^ chain[i];
   end

   assign rip_cout_o = chain[GRP_W];
   assign blk_prop_o = &props;

   // R4: the bypass is only logically redundant if the ripple agrees with it
   always_comb begin
      if (!$isunknown({pg_i, cin_i})) begin
         if (blk_prop_o) begin
            p_bypass_agrees_r4: assert (rip_cout_o == cin_i)
               else $error("rippled carry differs from bypassed carry");
            p_prop_no_gen_r3: assert (gens == '0)
               else $error("generate high inside a fully propagating group");
         end
      end
   end

endmodule

// File: rtl/cba_skip_sel.sv
module cba_skip_sel (
   input  logic sel_i,
   input  logic bypass_c_i,
   input  logic rippled_c_i,
   output logic carry_o
);

   always_comb begin
      if (sel_i) carry_o = bypass_c_i;
      else       carry_o = rippled_c_i;
   end

endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder
   import cba_pkg::*;
#(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned GRP_W  = 4,
   parameter bit          BYPASS = 1'b1
)(
   input  logic [WIDTH-1:0]              a_i,
   input  logic [WIDTH-1:0]              b_i,
   input  logic                          cin_i,
   output logic [WIDTH-1:0]              sum_o,
   output logic                          cout_o,
   output logic [WIDTH/GRP_W-1:0]        grp_prop_o
);

   localparam int unsigned NGRP = grp_count(WIDTH, GRP_W);

   if (GRP_W == 0 || WIDTH == 0) begin : g_chk_zero
      $error("WIDTH and GRP_W must be nonzero");
   end
   if (WIDTH % GRP_W != 0) begin : g_chk_div
      $error("WIDTH must be a multiple of GRP_W");
   end

   pg_bit_t [WIDTH-1:0] pg;
   logic    [NGRP:0]    gcarry;
   logic    [NGRP-1:0]  rip_c;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pg
      cba_pg_cell u_pg (
         .a_i  (a_i[i]),
         .b_i  (b_i[i]),
         .pg_o (pg[i])
      );
   end

   assign gcarry[0] = cin_i;

   for (genvar k = 0; k < NGRP; k++) begin : g_grp
      cba_ripple_group #(.GRP_W(GRP_W)) u_rip (
         .pg_i       (pg[k*GRP_W +: GRP_W]),
         .cin_i      (gcarry[k]),
         .sum_o      (sum_o[k*GRP_W +: GRP_W]),
         .rip_cout_o (rip_c[k]),
         .blk_prop_o (grp_prop_o[k])
      );

      if (BYPASS) begin : g_skip
         cba_skip_sel u_sel (
            .sel_i       (grp_prop_o[k]),
            .bypass_c_i  (gcarry[k]),
            .rippled_c_i (rip_c[k]),
            .carry_o     (gcarry[k+1])
         );
      end else begin : g_plain
         assign gcarry[k+1] = rip_c[k];
      end
   end

   assign cout_o = gcarry[NGRP];

   // R1, R2: result equals the arithmetic sum
   always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
         p_sum_matches_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("sum mismatch");
         // R4: a fully propagating operand pair returns the carry-in unchanged
         if ((a_i ^ b_i) == '1) begin
            p_full_prop_r4: assert (cout_o == cin_i && grp_prop_o == '1)
               else $error("full propagate path broken");
         end
      end
   end

endmodule

// File: tb/carry_skip_adder_test.sv
module carry_skip_adder_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] a, b;
   logic        cin;
   logic [15:0] sum;
   logic        cout;
   logic [3:0]  gp;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   carry_skip_adder uut (
      .a_i        (a),
      .b_i        (b),
      .cin_i      (cin),
      .sum_o      (sum),
      .cout_o     (cout),
      .grp_prop_o (gp)
   );

   // {a, b, cin, sum, cout, grp_prop}
   localparam int NV = 14;
   localparam logic [53:0] VEC [NV] = '{
      {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'h0},  // R1 zero
      {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, 4'h0},  // R1 carry-in only
      {16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 4'hF},  // R4
      {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 4'hF},  // R4
      {16'h5A5A, 16'hA5A5, 1'b0, 16'hFFFF, 1'b0, 4'hF},  // R4
      {16'h5A5A, 16'hA5A5, 1'b1, 16'h0000, 1'b1, 4'hF},  // R4
      {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'hE},  // R6
      {16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0, 4'h6},  // R5
      {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 4'h0},  // R1
      {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 4'h0},  // R2
      {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 4'h6},  // R5
      {16'h00F0, 16'hFF0F, 1'b1, 16'h0000, 1'b1, 4'hF},  // R4
      {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 4'h0},  // R2
      {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 4'h0}   // R3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%0b)", req, act, exp, a, b, cin);
      end
   endtask

   function automatic logic [3:0] model_gp(input logic [15:0] x, input logic [15:0] y);
      logic [15:0] d;
      logic [3:0]  r;
      d = x ^ y;
      for (int k = 0; k < 4; k++) r[k] = (d[4*k +: 4] == 4'hF);
      return r;
   endfunction

   task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
      @(posedge clk);
      a   = x;
      b   = y;
      cin = c;
      @(negedge clk);
   endtask

   task automatic check_model(input string tag);
      logic [16:0] full;
      full = {1'b0, a} + {1'b0, b} + {16'h0, cin};
      check({tag, " R1 sum"}, {16'h0, sum}, {16'h0, full[15:0]});
      check({tag, " R2 cout"}, {31'h0, cout}, {31'h0, full[16]});
      check({tag, " R3 grp_prop"}, {28'h0, gp}, {28'h0, model_gp(a, b)});
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: idle state with zero operands held through reset
      check("R1 reset sum", {16'h0, sum}, 32'h0);
      check("R2 reset cout", {31'h0, cout}, 32'h0);
      check("R3 reset grp_prop", {28'h0, gp}, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][53:38], VEC[i][37:22], VEC[i][21]);
         check("R1 table sum", {16'h0, sum}, {16'h0, VEC[i][20:5]});
         check("R2 table cout", {31'h0, cout}, {31'h0, VEC[i][4]});
         check("R3 table grp_prop", {28'h0, gp}, {28'h0, VEC[i][3:0]});
      end

      // R4: every bit propagates, carry-in toggled
      lfsr = 32'hACE1_1234;
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr[15:0], ~lfsr[15:0], i[0]);
         check("R4 bypass sum", {16'h0, sum}, i[0] ? 32'h0 : 32'hFFFF);
         check("R4 bypass cout", {31'h0, cout}, {31'h0, i[0]});
         check("R4 bypass grp_prop", {28'h0, gp}, 32'hF);
      end

      // R5: carry generated just below a fully propagating group
      for (int k = 1; k < 4; k++) begin
         logic [15:0] x, y;
         x = (16'hF << (4*k)) | (16'h1 << (4*k-1));
         y = 16'h1 << (4*k-1);
         apply(x, y, 1'b0);
         check("R5 group sum zero", {28'h0, sum[4*k +: 4]}, 32'h0);
         if (k < 3) check("R5 carry lands above group", {31'h0, sum[4*k+4]}, 32'h1);
         else       check("R5 carry lands in cout", {31'h0, cout}, 32'h1);
         check_model("R5");
      end

      // R6: carry from bit 0 across every group, both with and without carry-in
      apply(16'hFFFF, 16'h0001, 1'b0);
      check("R6 sum", {16'h0, sum}, 32'h0);
      check("R6 cout", {31'h0, cout}, 32'h1);
      check("R6 grp_prop", {28'h0, gp}, 32'hE);
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R6 cin ripple cout", {31'h0, cout}, 32'h1);

      // pseudo-random sweep against a behavioural adder
      for (int i = 0; i < 2000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr[15:0], lfsr[31:16] ^ {lfsr[7:0], lfsr[15:8]}, lfsr[5]);
         check_model("sweep");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule